// File: doc/BRIEF.md
# Chassis Power and Reset Button Pulser

This block drives the power-button and reset-button lines of a host chassis. A single-cycle command strobe selects one of four actions: power down, power up, hard reset, or power cycle. Each action produces a timed low pulse on the chosen line. Pulse lengths are counted in milliseconds. The millisecond time base comes from a two-stage divider of the system clock. The first stage is a fixed prescaler and the second is a compare-and-clear counter whose terminal count is a parameter.

Both lines are open-drain and active low. An asserted line has its output enable set and its pad value at zero. A released line clears its output enable and floats, so the block never drives a line high. The power line and the reset line have independent counters, and both may run at the same time.

A power pulse already in progress is never extended or restarted by a later command. A power cycle chains three phases: a power-off-length pulse, then a pause, then a power-on-length pulse. The pause only advances while no power pulse is running. Codes outside the four actions raise a one-cycle flag and otherwise do nothing.

Top module: `chassis_pulser`

## Requirements
- R1: After reset both output enables are low, busy is low and the unknown-command flag is low.
- R2: The time base ticks once every PRE_DIV*(TICK_TOP+1) clock cycles, with both divider stages restarting at reset. A pulse of N ticks that starts with a command lasts between (N-1)*period+1 and N*period cycles. Every line change after the start edge falls on a tick edge.
- R3: Code 2'b00 (power down) asserts the power line at the command edge for PDN_MS ticks. The reset line is not touched.
- R4: Code 2'b01 (power up) asserts the power line for PUP_MS ticks.
- R5: Code 2'b10 (hard reset) asserts the reset line for RST_MS ticks. Its counter runs independently of, and at the same time as, the power counter.
- R6: A power command issued while the power counter is nonzero leaves that counter unchanged. The running pulse keeps its original end time.
- R7: Code 2'b11 (power cycle) starts a PDN_MS power pulse, then keeps the line released for PAUSE_MS ticks, then asserts it again for PUP_MS ticks.
- R8: The pause counter advances only on ticks where the power counter is zero. A power pulse started during the pause freezes the pause until that pulse ends.
- R9: When a reset pulse ends on the same tick that a pause ends, the reset line is released and the power line is asserted at the same clock edge.
- R10: A valid command whose code is 4 or above (any nonzero bit above bit 1) sets unknown_o for exactly the next cycle and changes neither line nor busy.
- R11: busy_o is high whenever the power, pause or reset counter is nonzero, including while both lines are released during a pause.
- R12: Both pad value outputs stay at 0 at all times, so an asserted line is driven low and a released line floats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Single-cycle command strobe |
| cmd_code_i | input | CMD_W | Action code; 0 power down, 1 power up, 2 hard reset, 3 power cycle |
| unknown_o | output | 1 | Pulses for one cycle after an unimplemented code |
| busy_o | output | 1 | Any pulse or pause counter is nonzero |
| pwr_oe_o | output | 1 | Power line output enable (1 = driven low) |
| pwr_out_o | output | 1 | Power line pad value, always 0 |
| rst_oe_o | output | 1 | Reset line output enable (1 = driven low) |
| rst_out_o | output | 1 | Reset line pad value, always 0 |

## Verification
Two functions can fall in the same cycle: the end of a reset pulse and the end of a power-cycle pause, which re-asserts the power line. The bench issues a power cycle and then a hard reset exactly six tick periods later, so both counters reach zero on the ninth tick after the first command. At the edge where the power line rises, it checks that the reset line fell at that same edge and was still asserted one cycle earlier. A second overlap places a power-up command inside a pause. The bench then checks the exact tick counts of the frozen pause and the resumed pause.

// File: rtl/chassis_pkg.sv
package chassis_pkg;
  typedef enum logic [1:0] {
    ACT_PWR_DOWN  = 2'b00,
    ACT_PWR_UP    = 2'b01,
    ACT_HARD_RST  = 2'b10,
    ACT_PWR_CYCLE = 2'b11
  } chassis_act_e;
endpackage

// File: rtl/ms_tick_gen.sv
module ms_tick_gen #(
  parameter int PRE_DIV  = 4,
  parameter int TICK_TOP = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int PRE_W = $clog2(PRE_DIV + 1);
  localparam int CMP_W = $clog2(TICK_TOP + 2);
  localparam int PERIOD = PRE_DIV * (TICK_TOP + 1);

  logic [PRE_W-1:0] pre_q;
  logic [CMP_W-1:0] cmp_q;
  logic             pre_wrap;

  assign pre_wrap = (pre_q == PRE_W'(PRE_DIV - 1));
  assign tick_o   = pre_wrap && (cmp_q == CMP_W'(TICK_TOP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cmp_q <= '0;
    end else begin
      pre_q <= pre_wrap ? '0 : pre_q + 1'b1;
      if (pre_wrap) cmp_q <= (cmp_q == CMP_W'(TICK_TOP)) ? '0 : cmp_q + 1'b1;
    end
  end

  generate
    if (PERIOD > 1) begin : g_spacing
      // R2
      tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
  parameter int CNT_W  = 16,
  parameter bit RELOAD = 1'b0  // 1: load always wins; 0: load only when idle
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             active_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             take;

  assign take     = load_i && (RELOAD || cnt_q == '0);
  assign active_o = (cnt_q != '0);
  assign done_o   = tick_i && (cnt_q == CNT_W'(1)) && !take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (take)                  cnt_q <= len_i;
    else if (tick_i && active_o)    cnt_q <= cnt_q - 1'b1;
  end

  // R2
  tick_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q != '0 && !load_i) |=> cnt_q == $past(cnt_q) - 1'b1);

  generate
    if (!RELOAD) begin : g_hold
      // R6
      no_retrigger_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q != '0 && !tick_i) |=> $stable(cnt_q));
    end
  endgenerate
endmodule

// File: rtl/chassis_pulser.sv
module chassis_pulser
  import chassis_pkg::*;
#(
  parameter int CMD_W    = 3,
  parameter int PRE_DIV  = 4,
  parameter int TICK_TOP = 3,
  parameter int CNT_W    = 16,
  parameter int PDN_MS   = 4,
  parameter int PUP_MS   = 3,
  parameter int RST_MS   = 3,
  parameter int PAUSE_MS = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_code_i,
  output logic             unknown_o,
  output logic             busy_o,
  output logic             pwr_oe_o,
  output logic             pwr_out_o,
  output logic             rst_oe_o,
  output logic             rst_out_o
);
  localparam logic [CNT_W-1:0] PDN_LEN   = CNT_W'(PDN_MS);
  localparam logic [CNT_W-1:0] PUP_LEN   = CNT_W'(PUP_MS);
  localparam logic [CNT_W-1:0] RST_LEN   = CNT_W'(RST_MS);
  localparam logic [CNT_W-1:0] PAUSE_LEN = CNT_W'(PAUSE_MS);

  logic         tick;
  logic         cmd_known;
  chassis_act_e act;
  logic         go_down, go_up, go_rst, go_cycle;
  logic         pwr_act, pwr_done, pause_act, pause_done, rst_act, rst_done;
  logic         pwr_load;
  logic [CNT_W-1:0] pwr_len;
  logic         unknown_q;

  assign act       = chassis_act_e'(cmd_code_i[1:0]);
  assign cmd_known = ((cmd_code_i >> 2) == '0);
  assign go_down   = cmd_valid_i && cmd_known && act == ACT_PWR_DOWN;
  assign go_up     = cmd_valid_i && cmd_known && act == ACT_PWR_UP;
  assign go_rst    = cmd_valid_i && cmd_known && act == ACT_HARD_RST;
  assign go_cycle  = cmd_valid_i && cmd_known && act == ACT_PWR_CYCLE;

  ms_tick_gen #(.PRE_DIV(PRE_DIV), .TICK_TOP(TICK_TOP)) u_tick (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  // command wins over pause expiry; pause expiry implies power counter idle
  assign pwr_load = go_down || go_up || go_cycle || pause_done;
  assign pwr_len  = (go_down || go_cycle) ? PDN_LEN : PUP_LEN;

  pulse_timer #(.CNT_W(CNT_W), .RELOAD(1'b0)) u_pwr (
    .clk_i, .rst_ni, .tick_i(tick), .load_i(pwr_load), .len_i(pwr_len),
    .active_o(pwr_act), .done_o(pwr_done)
  );

  // pause only advances while no power pulse runs
  pulse_timer #(.CNT_W(CNT_W), .RELOAD(1'b1)) u_pause (
    .clk_i, .rst_ni, .tick_i(tick && !pwr_act), .load_i(go_cycle), .len_i(PAUSE_LEN),
    .active_o(pause_act), .done_o(pause_done)
  );

  pulse_timer #(.CNT_W(CNT_W), .RELOAD(1'b0)) u_rst (
    .clk_i, .rst_ni, .tick_i(tick), .load_i(go_rst), .len_i(RST_LEN),
    .active_o(rst_act), .done_o(rst_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) unknown_q <= 1'b0;
    else         unknown_q <= cmd_valid_i && !cmd_known;
  end

  assign unknown_o = unknown_q;
  assign busy_o    = pwr_act || pause_act || rst_act;
  assign pwr_oe_o  = pwr_act;
  assign rst_oe_o  = rst_act;
  assign pwr_out_o = 1'b0;
  assign rst_out_o = 1'b0;

  // R11
  busy_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_oe_o || rst_oe_o) |-> busy_o);

  // R7
  cycle_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_done |=> pwr_oe_o);

  // R10
  unknown_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !cmd_known) |=> unknown_o);

  // R10
  unknown_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !cmd_known && !busy_o) |=> (!pwr_oe_o && !rst_oe_o && !busy_o));

  // R5
  rst_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_done && !go_rst) |=> !rst_oe_o);
endmodule

// File: tb/chassis_pulser_bench.sv
`timescale 1ns/1ps
module chassis_pulser_bench;
  localparam int P = 16;
  localparam int PDN = 4, PUP = 3, RST = 3, PAUSE = 5;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_code = '0;
  logic unknown, busy, pwr_oe, pwr_out, rst_oe, rst_out;
  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  chassis_pulser u_chassis_pulser (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_code_i(cmd_code),
    .unknown_o(unknown), .busy_o(busy), .pwr_oe_o(pwr_oe), .pwr_out_o(pwr_out),
    .rst_oe_o(rst_oe), .rst_out_o(rst_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // call at a negedge; returns the edge index at which the command is sampled
  task automatic send(input logic [2:0] code, output int e);
    cmd_valid = 1'b1;
    cmd_code  = code;
    @(negedge clk);
    cmd_valid = 1'b0;
    e = cyc;
  endtask

  task automatic wait_line(input bit use_rst, input logic lvl, output int e);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if ((use_rst ? rst_oe : pwr_oe) == lvl) break;
    end
    e = cyc;
  endtask

  task automatic go_to(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(pwr_oe == 0 && rst_oe == 0, "R1 lines released", {pwr_oe, rst_oe}, 0);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(unknown == 0, "R1 unknown", unknown, 0);
  endtask

  task automatic t_power_down;
    int c, e;
    send(3'd0, c);
    chk(pwr_oe == 1 && pwr_out == 0, "R3/R12 power asserted low", pwr_oe, 1);
    chk(rst_oe == 0, "R3 reset untouched", rst_oe, 0);
    wait_line(0, 1'b0, e);
    chk(e - c >= (PDN-1)*P+1 && e - c <= PDN*P, "R3/R2 down length", e - c, PDN*P);
    chk(busy == 0, "R11 busy clears", busy, 0);
  endtask

  task automatic t_power_up;
    int c, e;
    @(negedge clk);
    send(3'd1, c);
    chk(pwr_oe == 1, "R4 power asserted", pwr_oe, 1);
    wait_line(0, 1'b0, e);
    chk(e - c >= (PUP-1)*P+1 && e - c <= PUP*P, "R4 up length", e - c, PUP*P);
  endtask

  task automatic t_concurrent_reset;
    int c0, c1, e0, e1;
    @(negedge clk);
    send(3'd0, c0);
    send(3'd2, c1);
    chk(pwr_oe == 1 && rst_oe == 1 && rst_out == 0, "R5/R12 both asserted", {pwr_oe, rst_oe}, 3);
    wait_line(1, 1'b0, e1);
    chk(e1 - c1 >= (RST-1)*P+1 && e1 - c1 <= RST*P, "R5 reset length", e1 - c1, RST*P);
    chk(pwr_oe == 1, "R5 power still running", pwr_oe, 1);
    wait_line(0, 1'b0, e0);
    chk(e0 - c0 >= (PDN-1)*P+1 && e0 - c0 <= PDN*P, "R5 power length unaffected", e0 - c0, PDN*P);
  endtask

  task automatic t_retrigger;
    int c, x, e;
    @(negedge clk);
    send(3'd0, c);
    repeat (40) @(negedge clk);
    send(3'd1, x);
    chk(pwr_oe == 1, "R6 still asserted", pwr_oe, 1);
    send(3'd0, x);
    wait_line(0, 1'b0, e);
    chk(e - c >= (PDN-1)*P+1 && e - c <= PDN*P, "R6 not extended", e - c, PDN*P);
  endtask

  task automatic t_cycle;
    int c, e1, e2, e3;
    @(negedge clk);
    send(3'd3, c);
    chk(pwr_oe == 1, "R7 off pulse starts", pwr_oe, 1);
    wait_line(0, 1'b0, e1);
    chk(e1 - c >= (PDN-1)*P+1 && e1 - c <= PDN*P, "R7 off length", e1 - c, PDN*P);
    chk(busy == 1, "R11 busy during pause", busy, 1);
    wait_line(0, 1'b1, e2);
    chk(e2 - e1 == PAUSE*P, "R7 pause length", e2 - e1, PAUSE*P);
    wait_line(0, 1'b0, e3);
    chk(e3 - e2 == PUP*P, "R7 on length", e3 - e2, PUP*P);
    chk(busy == 0, "R11 busy after cycle", busy, 0);
  endtask

  task automatic t_pause_hold;
    int c, t0, x, e;
    @(negedge clk);
    send(3'd3, c);
    wait_line(0, 1'b0, t0);
    go_to(t0 + 2*P + 7);
    send(3'd1, x);
    chk(x == t0 + 2*P + 8 && pwr_oe == 1, "R8 up during pause", pwr_oe, 1);
    wait_line(0, 1'b0, e);
    chk(e - t0 == 5*P, "R8 inserted pulse end", e - t0, 5*P);
    chk(busy == 1, "R8 pause held", busy, 1);
    wait_line(0, 1'b1, e);
    chk(e - t0 == 8*P, "R8 pause resumes", e - t0, 8*P);
    wait_line(0, 1'b0, e);
    chk(e - t0 == 11*P, "R8 final on pulse", e - t0, 11*P);
  endtask

  task automatic t_same_tick;
    int c, x;
    logic prev_rst;
    @(negedge clk);
    send(3'd3, c);
    go_to(c + 6*P - 1);
    send(3'd2, x);
    chk(rst_oe == 1, "R9 reset running", rst_oe, 1);
    prev_rst = rst_oe;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (pwr_oe) break;
      prev_rst = rst_oe;
    end
    chk(cyc - c == 9*P || (cyc - c > 8*P && cyc - c <= 9*P), "R9 reassert tick", cyc - c, 9*P);
    chk(prev_rst == 1 && rst_oe == 0, "R9 reset ends same edge", {prev_rst, rst_oe}, 2);
    wait_line(0, 1'b0, x);
  endtask

  task automatic t_unknown;
    int c;
    @(negedge clk);
    send(3'd5, c);
    chk(unknown == 1, "R10 flag set", unknown, 1);
    chk(pwr_oe == 0 && rst_oe == 0 && busy == 0, "R10 no effect", {pwr_oe, rst_oe, busy}, 0);
    @(negedge clk);
    chk(unknown == 0, "R10 flag one cycle", unknown, 0);
    send(3'd4, c);
    chk(unknown == 1 && busy == 0, "R10 code 4", {unknown, busy}, 2);
    repeat (3*P) @(negedge clk);
    chk(pwr_oe == 0 && rst_oe == 0, "R10 lines stay released", {pwr_oe, rst_oe}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk);
    t_power_down;
    t_power_up;
    t_concurrent_reset;
    t_retrigger;
    t_cycle;
    t_pause_hold;
    t_same_tick;
    t_unknown;
    chk(pwr_out == 0 && rst_out == 0, "R12 pads never high", {pwr_out, rst_out}, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule